// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a slave-only port for a two-wire serial management bus (SMBus / I2C style). It lets a host on the bus read and write a bank of twelve 8-bit configuration registers. The block watches already-synchronized SCL and SDA inputs and finds START and STOP conditions. It compares the address byte against its own 7-bit address and then handles three kinds of byte: register-pointer writes, data writes and data reads. Register contents are presented in parallel on a flat output bus, so the rest of the chip can use them directly.

The port only ever pulls SDA low, through an open-drain enable. It has no SCL output and so never stretches the clock. It does tolerate other devices holding SCL low. A watchdog counts system-clock cycles while SCL is low. If one low interval runs past a programmable limit, the transfer is abandoned and SDA is released. The default limit is 30 ms of a 100 MHz clock, which lies between the 25 ms minimum and the 35 ms maximum for the bus timeout. A smaller value can be set for simulation.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register reads 00h on `regs_o` and `sda_pull_o` is low.
- R2: A START is SDA falling while SCL is high, and it begins an address phase. A STOP is SDA rising while SCL is high. A STOP at any point, including in the middle of a byte, returns the port to idle with SDA released and leaves the register being written unchanged.
- R3: The address byte is sent MSB first as seven address bits followed by a direction bit (0 = write, 1 = read). When the address equals `DEV_ADDR`, the port acknowledges by pulling SDA low for the whole of the ninth clock.
- R4: In a write transfer, the first byte after the address loads the register pointer and is acknowledged. Each later byte is stored into the register the pointer selects and is acknowledged, and the pointer then advances by one.
- R5: In a read transfer, the port sends the byte at the pointer MSB first and advances the pointer after each byte. A master ACK (SDA low on the ninth clock) gets the next byte. A master NACK releases SDA and ends the read. The pointer keeps its value across transfers.
- R6: When the address does not match, the port neither acknowledges nor drives SDA until the next START, and no register changes.
- R7: When the pointer is above 0Bh, data writes are not acknowledged and not stored, and reads return 00h. In both cases the transfer continues and the pointer still advances.
- R8: When SCL stays low for `TMO_CYC` consecutive clock cycles, the port releases SDA within one cycle and returns to idle. A START that follows is accepted normally.
- R9: The port has no SCL output. A low SCL interval held by another device, when shorter than the timeout, leaves the transfer intact.
- R10: A START followed immediately by a STOP leaves the port idle. Bits clocked after that without a new START are ignored.
- R11: With the default address, the alert-response address 0001100b is not acknowledged, and the port has no alert output.
- R12: A repeated START in the middle of a transfer restarts the address phase and keeps the current pointer, so a pointer write followed by a repeated START and a read returns the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | NREG*DW (96) | Register contents; register i sits at bits [8*i+7:8*i] |

## Verification
Each result of this block is due at a fixed distance from an SCL edge. A slave ACK or read data bit is driven one system clock after the SCL fall that ends the previous bit. The bench samples it in the middle of the following SCL high phase, well clear of that fall. A stored register appears on `regs_o` one cycle after the SCL fall that ends the data byte, and the bench reads the outputs only after the following STOP. For the timeout, the bench checks that SDA is still pulled about 100 cycles before the limit and released about 50 cycles after it, so that one cycle of skew between the line and the watchdog cannot move the result.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int DATA_W   = 8;
    localparam int REG_CNT  = 12;
    localparam int PTR_W    = 8;
    localparam int BITCNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    function automatic logic is_rx_state(slv_state_e s);
        return (s == ST_ADDR) || (s == ST_PTR) || (s == ST_WDAT);
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon
    import smb_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.sda   = sda_i;
    end
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
    parameter int LIMIT = 3_000_000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic tmo
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || scl_i) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tmo = ~scl_i && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int NREG = smb_cfg_pkg::REG_CNT,
    parameter int DW   = smb_cfg_pkg::DATA_W,
    parameter int AW   = smb_cfg_pkg::PTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] flat
);
    localparam logic [AW-1:0] TOP = AW'(NREG);

    logic [DW-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && wr_addr == AW'(i)) begin
                mem[i] <= wr_data;
            end
        end
        assign flat[i*DW +: DW] = mem[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = mem[i];
        end
    end

    // R7: the controller must never strobe a write outside the bank
    a_r7_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr < TOP));

    // R6: without a strobe the contents hold
    a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int TMO_CYC          = 3_000_000,
    parameter int NREG             = REG_CNT,
    parameter int DW               = DATA_W,
    localparam int RW              = NREG * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull_o,
    output logic [RW-1:0] regs_o
);
    localparam logic [PTR_W-1:0]    TOP  = PTR_W'(NREG);
    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(DW);

    line_ev_t            ev;
    logic                tmo;
    slv_state_e          st, ret;
    logic [DW-1:0]       sh, tx;
    logic [BITCNT_W-1:0] cnt;
    logic [PTR_W-1:0]    ptr, rd_addr;
    logic [DW-1:0]       rd_data;
    logic                mack, wr_en;

    smb_line_mon u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_low_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .tmo   (tmo)
    );

    assign wr_en   = (st == ST_WDAT) && ev.fall && (cnt == FULL) && (ptr < TOP)
                     && !tmo && !ev.start && !ev.stop;
    assign rd_addr = (st == ST_MACK) ? ptr + 1'b1 : ptr;

    smb_reg_bank #(.NREG(NREG), .DW(DW), .AW(PTR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (sh),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flat    (regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ret        <= ST_IDLE;
            sh         <= '0;
            tx         <= '0;
            cnt        <= '0;
            ptr        <= '0;
            mack       <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (tmo) begin
            st         <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else if (ev.start) begin
            st         <= ST_ADDR;
            cnt        <= '0;
            sda_pull_o <= 1'b0;
        end else if (ev.stop) begin
            st         <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (ev.rise) begin
                        sh  <= {sh[DW-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall && cnt == FULL) begin
                        cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (sh[DW-1:1] == DEV_ADDR) begin
                                sda_pull_o <= 1'b1;
                                st         <= ST_ACK;
                                ret        <= sh[0] ? ST_TX : ST_PTR;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else if (st == ST_PTR) begin
                            ptr        <= sh;
                            sda_pull_o <= 1'b1;
                            st         <= ST_ACK;
                            ret        <= ST_WDAT;
                        end else begin
                            ptr        <= ptr + 1'b1;
                            sda_pull_o <= (ptr < TOP);
                            st         <= ST_ACK;
                            ret        <= ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        st  <= ret;
                        cnt <= '0;
                        if (ret == ST_TX) begin
                            tx         <= rd_data;
                            sda_pull_o <= ~rd_data[DW-1];
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall) begin
                        if (cnt == FULL) begin
                            sda_pull_o <= 1'b0;
                            st         <= ST_MACK;
                            cnt        <= '0;
                        end else begin
                            tx         <= {tx[DW-2:0], 1'b0};
                            sda_pull_o <= ~tx[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.fall) begin
                        ptr <= ptr + 1'b1;
                        if (mack) begin
                            tx         <= rd_data;
                            sda_pull_o <= ~rd_data[DW-1];
                            st         <= ST_TX;
                            cnt        <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: a watchdog expiry leaves the bus released and the port idle
    a_r8_timeout_releases: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (!sda_pull_o && st == ST_IDLE));

    // R6: a non-addressed port stays off the bus
    a_r6_ignore_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> !sda_pull_o);

    // R2: idle never drives
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_pull_o);

    // R10: a detected stop always lands in idle
    a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !tmo) |=> (st == ST_IDLE));

    // R3: bit counter never passes a full byte while shifting
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        is_rx_state(st) |-> (cnt <= FULL));
endmodule

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
    localparam int H    = 10;
    localparam int TMO  = 600;
    localparam logic [6:0] ADR = 7'h2C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [95:0] regs;
    logic bus_sda;
    int   stretch = 0;
    int   checks = 0;
    int   errors = 0;
    logic [7:0] model [12];

    always #5 clk = ~clk;
    assign bus_sda = sda_m & ~sda_pull;

    smb_cfg_slave #(.DEV_ADDR(ADR), .TMO_CYC(TMO)) u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (bus_sda),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic observe(input logic [7:0] act);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard-empty actual %h expected none", act);
        end else begin
            e = exp_q.pop_front();
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s actual %h expected %h", e.tag, act, e.v);
            end
        end
    endtask

    task automatic check_eq(input logic [95:0] act, input logic [95:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] model_flat();
        logic [95:0] f;
        for (int i = 0; i < 12; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;
        wait_n(H + stretch);
        scl = 1'b1;
        wait_n(H / 2);
        s = bus_sda;
        wait_n(H / 2);
        scl = 1'b0;
        wait_n(2);
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_n(H);
        scl = 1'b1;
        wait_n(H);
        sda_m = 1'b0;
        wait_n(H);
        scl = 1'b0;
        wait_n(H);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wait_n(H);
        scl = 1'b1;
        wait_n(H);
        sda_m = 1'b1;
        wait_n(H);
    endtask

    // driver: pushes the expected acknowledge (0 = ACK) then clocks the byte
    task automatic send_byte(input logic [7:0] d, input logic exp_nack, input string tag);
        logic s;
        push_exp({7'd0, exp_nack}, tag);
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        observe({7'd0, s});
    endtask

    task automatic read_byte(input logic [7:0] exp, input logic give_ack, input string tag);
        logic s;
        logic [7:0] got;
        push_exp(exp, tag);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            got[i] = s;
        end
        clk_bit(~give_ack, s);
        observe(got);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) model[i] = 8'h00;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);

        // R1 reset state
        check_eq(regs, 96'h0, "R1 regs after reset");
        check_eq({95'h0, sda_pull}, 96'h0, "R1 sda released after reset");

        // R3 R4 pointer write then burst data
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R3 address ack");
        send_byte(8'h02, 1'b0, "R4 pointer ack");
        send_byte(8'hA1, 1'b0, "R4 data ack");
        send_byte(8'hB2, 1'b0, "R4 data ack");
        send_byte(8'hC3, 1'b0, "R4 data ack");
        do_stop();
        model[2] = 8'hA1; model[3] = 8'hB2; model[4] = 8'hC3;
        check_eq(regs, model_flat(), "R4 burst stored");

        // R12 R5 repeated start read with auto-increment
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R12 address ack");
        send_byte(8'h03, 1'b0, "R12 pointer ack");
        do_start();
        send_byte({ADR, 1'b1}, 1'b0, "R12 read address ack");
        read_byte(8'hB2, 1'b1, "R12 first read byte");
        read_byte(8'hC3, 1'b0, "R5 incremented read byte");
        do_stop();
        check_eq({95'h0, sda_pull}, 96'h0, "R5 released after nack");
        do_start();
        send_byte({ADR, 1'b1}, 1'b0, "R5 read address ack");
        read_byte(8'h00, 1'b0, "R5 pointer kept across transfers");
        do_stop();

        // R7 past the end of the bank
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R7 address ack");
        send_byte(8'h0A, 1'b0, "R7 pointer ack");
        send_byte(8'h11, 1'b0, "R7 write 0Ah ack");
        send_byte(8'h22, 1'b0, "R7 write 0Bh ack");
        send_byte(8'h33, 1'b1, "R7 write 0Ch nack");
        send_byte(8'h44, 1'b1, "R7 write 0Dh nack");
        do_stop();
        model[10] = 8'h11; model[11] = 8'h22;
        check_eq(regs, model_flat(), "R7 out of range not stored");
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R7 address ack");
        send_byte(8'h0B, 1'b0, "R7 pointer ack");
        do_start();
        send_byte({ADR, 1'b1}, 1'b0, "R7 read address ack");
        read_byte(8'h22, 1'b1, "R7 read 0Bh");
        read_byte(8'h00, 1'b1, "R7 read 0Ch zero");
        read_byte(8'h00, 1'b0, "R7 read 0Dh zero");
        do_stop();

        // R6 foreign address
        do_start();
        send_byte({7'h2D, 1'b0}, 1'b1, "R6 foreign address nack");
        send_byte(8'h00, 1'b1, "R6 ignored pointer");
        send_byte(8'h55, 1'b1, "R6 ignored data");
        do_stop();
        check_eq(regs, model_flat(), "R6 no register change");

        // R11 alert response address
        do_start();
        send_byte({7'h0C, 1'b1}, 1'b1, "R11 alert address nack");
        do_stop();

        // R9 stretched clock-low below the timeout
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R9 address ack");
        send_byte(8'h00, 1'b0, "R9 pointer ack");
        stretch = 400;
        send_byte(8'h5A, 1'b0, "R9 stretched data ack");
        stretch = 0;
        do_stop();
        model[0] = 8'h5A;
        check_eq(regs, model_flat(), "R9 stretched byte stored");

        // R8 timeout while the slave holds the acknowledge
        begin
            logic s;
            do_start();
            for (int i = 7; i >= 0; i--) clk_bit(((i == 0) ? 1'b0 : ADR[i-1]), s);
            wait_n(500);
            check_eq({95'h0, sda_pull}, 96'h1, "R8 ack still held before limit");
            wait_n(150);
            check_eq({95'h0, sda_pull}, 96'h0, "R8 released after limit");
            do_stop();
        end
        do_start();
        send_byte({ADR, 1'b0}, 1'b0, "R8 recovery address ack");
        send_byte(8'h01, 1'b0, "R8 recovery pointer ack");
        send_byte(8'h77, 1'b0, "R8 recovery data ack");
        do_stop();
        model[1] = 8'h77;
        check_eq(regs, model_flat(), "R8 recovery write stored");

        // R10 start then stop, then bits without a start
        do_start();
        do_stop();
        scl = 1'b0;
        wait_n(H);
        send_byte({ADR, 1'b0}, 1'b1, "R10 bits after start-stop ignored");
        do_stop();

        // R2 stop in the middle of a data byte
        begin
            logic s;
            do_start();
            send_byte({ADR, 1'b0}, 1'b0, "R2 address ack");
            send_byte(8'h06, 1'b0, "R2 pointer ack");
            for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
            do_stop();
        end
        check_eq(regs, model_flat(), "R2 partial byte discarded");
        check_eq({95'h0, sda_pull}, 96'h0, "R2 released after stop");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule